// File: doc/BRIEF.md
# Programmable Phase Calibration Delay

This block lines up a current sample stream with a voltage sample stream before the two are multiplied downstream. Both streams arrive as signed words and share one sample strobe, which runs at the fine time-step rate of roughly 0.98 µs. The block holds back one of the two streams by a whole number of strobes. At that step rate, each step is worth about 0.0176° of a 50 Hz cycle or 0.0211° of a 60 Hz cycle.

A single 10-bit calibration code selects both the delayed channel and the delay length. It is written and read through a plain 16-bit register port. A code with the top bit clear means the current leads, and the current channel is delayed by the code value, up to 383 steps. A code with the top bit set means the current lags, and the voltage channel is delayed by the code minus 512, up to 63 steps. Codes outside these two ranges are refused, and the previous setting stays in force. Each channel's delay is built as a circular buffer. The buffer is never cleared, so a new setting is used on the very next strobe against the history already held.

Top module: `phase_skew_comp`

## Requirements
- R1: After reset the stored code is 0, `cfg_rdata` reads 0x0000, and both sample outputs are 0.
- R2: `cfg_rdata` always returns the stored 10-bit code in bits 9:0, with bits 15:10 at zero.
- R3: A write of a value from 0 to 383 is stored. The current output then presents the current sample from that many strobes earlier, and the voltage output passes the voltage sample of the same strobe.
- R4: A write of a value from 512 to 575 is stored. The voltage output then presents the voltage sample from (value − 512) strobes earlier, and the current output passes the current sample of the same strobe.
- R5: A write of a value from 384 to 511, or from 576 to 1023, is refused, and the stored code and the delays stay unchanged.
- R6: A write whose bits 15:10 are not all zero is ignored, whatever its lower bits hold.
- R7: A delay of 0 shows the sample given on a strobe at the output right after that strobe's clock edge.
- R8: While fewer samples have been written since reset than the selected delay, the delayed output is 0.
- R9: A new code is used from the next strobe onward, and samples stored before the change stay usable.
- R10: Between strobes both outputs hold their values, even when the sample inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe; each high cycle takes in one sample pair |
| cur_in | input | SW | Signed current sample |
| volt_in | input | SW | Signed voltage sample |
| cfg_wr | input | 1 | Register write enable |
| cfg_wdata | input | 16 | Register write word |
| cfg_rdata | output | 16 | Register read word: stored code with six zero upper bits |
| cur_out | output | SW | Realigned current sample |
| volt_out | output | SW | Realigned voltage sample |

## Verification
The in-line assertions check the following on every cycle:
- Refused and padded writes leave the stored code untouched.
- At most one channel carries a nonzero delay.
- The outputs stay frozen between strobes.
- A zero delay passes the incoming sample through.
- Warm-up outputs stay zero.

Only the bench's scenarios can show that a delayed sample is the right historical sample. Its scoreboard follows the full sample history through code changes, switches between lead and lag, the extreme delays of 383 and 63, and a second reset. It checks the delayed value on every strobe.

// File: rtl/phsk_pkg.sv
package phsk_pkg;
   localparam int CAL_W   = 10;
   localparam int REG_W   = 16;
   localparam int LAG_POS = CAL_W - 1;
   localparam int unsigned LAG_BASE = 32'd1 << LAG_POS;

   typedef logic [CAL_W-1:0] cal_code_t;

   typedef struct packed {
      logic             lag;
      logic [CAL_W-2:0] mag;
   } cal_fields_t;

   // legal register word: zero padding and inside one of the two windows
   function automatic logic word_ok(input logic [REG_W-1:0] w,
                                    input int unsigned lead_max,
                                    input int unsigned lag_max);
      int unsigned v;
      v = {{(32-REG_W){1'b0}}, w};
      return (w[REG_W-1:CAL_W] == '0) &&
             ((v <= lead_max) || ((v >= LAG_BASE) && (v <= LAG_BASE + lag_max)));
   endfunction
endpackage

// File: rtl/phsk_cal_reg.sv
module phsk_cal_reg
   import phsk_pkg::*;
#(
   parameter int unsigned LEAD_MAX = 383,
   parameter int unsigned LAG_MAX  = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output cal_code_t        code
);
   cal_code_t code_q;
   logic      accept;

   initial begin
      assert (LEAD_MAX < LAG_BASE) else $error("lead window overlaps lag flag");
      assert (LAG_MAX < LAG_BASE)  else $error("lag window too wide");
   end

   assign accept = wr_en && word_ok(wdata, LEAD_MAX, LAG_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n)      code_q <= '0;
      else if (accept) code_q <= wdata[CAL_W-1:0];
   end

   assign code  = code_q;
   assign rdata = {{(REG_W-CAL_W){1'b0}}, code_q};

   p_reject_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wdata[REG_W-1:CAL_W] == '0) && !word_ok(wdata, LEAD_MAX, LAG_MAX))
      |=> $stable(rdata));

   p_reject_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wdata[REG_W-1:CAL_W] != '0)) |=> $stable(code));

   p_stored_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      word_ok(rdata, LEAD_MAX, LAG_MAX));
endmodule

// File: rtl/phsk_delay_line.sv
module phsk_delay_line #(
   parameter int SW      = 24,
   parameter int MAX_DLY = 383,
   localparam int DEPTH  = MAX_DLY + 1,
   localparam int PW     = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stb,
   input  logic signed [SW-1:0] din,
   input  logic [PW-1:0]        dly,
   output logic signed [SW-1:0] dout
);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic signed [SW-1:0] mem [DEPTH];
   logic [PW-1:0]        wptr, wnext, rptr, fill;
   logic signed [SW-1:0] pick;

   initial begin
      assert (MAX_DLY >= 1) else $error("delay line needs at least one stage");
      assert (SW >= 2)      else $error("sample width too small");
   end

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign rptr  = wptr - dly;
         assign wnext = wptr + 1'b1;
      end else begin : g_wrap
         assign rptr  = (wptr >= dly) ? (wptr - dly) : (wptr + PW'(DEPTH) - dly);
         assign wnext = (wptr == LAST) ? '0 : (wptr + 1'b1);
      end
   endgenerate

   always_comb begin
      if (dly == '0)       pick = din;
      else if (fill >= dly) pick = mem[rptr];
      else                  pick = '0;
   end

   always_ff @(posedge clk) begin
      if (stb) mem[wptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         fill <= '0;
         dout <= '0;
      end else if (stb) begin
         wptr <= wnext;
         if (fill != LAST) fill <= fill + 1'b1;
         dout <= pick;
      end
   end

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(dout));

   p_zero_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && dly == '0) |=> (dout == $past(din)));

   p_warmup_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && fill < dly) |=> (dout == '0));

   p_ptr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wptr <= LAST) && (dly <= LAST));
endmodule

// File: rtl/phase_skew_comp.sv
module phase_skew_comp
   import phsk_pkg::*;
#(
   parameter int SW                = 24,
   parameter int unsigned LEAD_MAX = 383,
   parameter int unsigned LAG_MAX  = 63
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_stb,
   input  logic signed [SW-1:0] cur_in,
   input  logic signed [SW-1:0] volt_in,
   input  logic                 cfg_wr,
   input  logic [REG_W-1:0]     cfg_wdata,
   output logic [REG_W-1:0]     cfg_rdata,
   output logic signed [SW-1:0] cur_out,
   output logic signed [SW-1:0] volt_out
);
   localparam int CDW = (LEAD_MAX + 1 > 2) ? $clog2(LEAD_MAX + 1) : 1;
   localparam int VDW = (LAG_MAX + 1 > 2)  ? $clog2(LAG_MAX + 1)  : 1;

   cal_code_t     code;
   cal_fields_t   fld;
   logic [CDW-1:0] cur_dly;
   logic [VDW-1:0] volt_dly;

   initial begin
      assert (CDW <= CAL_W - 1) else $error("lead delay wider than magnitude field");
      assert (VDW <= CAL_W - 1) else $error("lag delay wider than magnitude field");
   end

   phsk_cal_reg #(.LEAD_MAX(LEAD_MAX), .LAG_MAX(LAG_MAX)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cfg_wr),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .code  (code)
   );

   assign fld      = code;
   assign cur_dly  = fld.lag ? '0 : fld.mag[CDW-1:0];
   assign volt_dly = fld.lag ? fld.mag[VDW-1:0] : '0;

   phsk_delay_line #(.SW(SW), .MAX_DLY(int'(LEAD_MAX))) u_cur (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (smp_stb),
      .din   (cur_in),
      .dly   (cur_dly),
      .dout  (cur_out)
   );

   phsk_delay_line #(.SW(SW), .MAX_DLY(int'(LAG_MAX))) u_volt (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (smp_stb),
      .din   (volt_in),
      .dly   (volt_dly),
      .dout  (volt_out)
   );

   p_one_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_dly == '0) || (volt_dly == '0));

   p_lag_routes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[CAL_W-1] |-> (cur_dly == '0));
endmodule

// File: tb/tb_phase_skew_comp.sv
module tb_phase_skew_comp;
   localparam int SW = 24;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 smp_stb = 1'b0;
   logic signed [SW-1:0] cur_in = '0, volt_in = '0;
   logic                 cfg_wr = 1'b0;
   logic [15:0]          cfg_wdata = '0;
   logic [15:0]          cfg_rdata;
   logic signed [SW-1:0] cur_out, volt_out;

   int checks = 0, fails = 0, sid = 0, code_m = 0;
   bit done = 1'b0;
   logic stb_seen = 1'b0;
   logic signed [SW-1:0] ch[$], vh[$], ec_q[$], ev_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   phase_skew_comp #(.SW(SW)) dut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .cur_in(cur_in), .volt_in(volt_in),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .cur_out(cur_out), .volt_out(volt_out));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit legal(input int w);
      return ((w >> 10) == 0) && ((w <= 383) || (w >= 512 && w <= 575));
   endfunction

   // monitor: compare outputs in the cycle after each strobe edge
   always @(posedge clk) stb_seen <= smp_stb;
   always @(negedge clk) begin
      if (stb_seen) begin
         if (ec_q.size() == 0) chk(1'b0, "scoreboard underflow", 0, 1);
         else begin
            logic signed [SW-1:0] ec, ev;
            string t;
            ec = ec_q.pop_front(); ev = ev_q.pop_front(); t = tag_q.pop_front();
            chk(cur_out == ec, {t, " current"}, cur_out, ec);
            chk(volt_out == ev, {t, " voltage"}, volt_out, ev);
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      ch.delete(); vh.delete();
      code_m = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic strobe(input string tag);
      int n, cd, vd;
      logic signed [SW-1:0] cs, vs;
      cs = SW'(sid * 1237 - 50000);
      vs = SW'(777 - sid * 311);
      sid++;
      n = ch.size();
      ch.push_back(cs); vh.push_back(vs);
      cd = (code_m >= 512) ? 0 : code_m;
      vd = (code_m >= 512) ? code_m - 512 : 0;
      ec_q.push_back((n >= cd) ? ch[n - cd] : '0);
      ev_q.push_back((n >= vd) ? vh[n - vd] : '0);
      tag_q.push_back(tag);
      @(negedge clk);
      smp_stb = 1'b1; cur_in = cs; volt_in = vs;
      @(negedge clk);
      smp_stb = 1'b0;
   endtask

   task automatic wr(input int w, input string tag);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = 16'(w);
      @(negedge clk);
      cfg_wr = 1'b0;
      if (legal(w)) code_m = w;
      chk(cfg_rdata == 16'(code_m), tag, cfg_rdata, code_m);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R1: reset state
      chk(cfg_rdata == 16'h0000, "R1 rdata", cfg_rdata, 0);
      chk(cur_out == '0, "R1 cur_out", cur_out, 0);
      chk(volt_out == '0, "R1 volt_out", volt_out, 0);
      // R7: zero delay passes through on the same strobe
      for (int i = 0; i < 5; i++) strobe("R7 pass-through");
      do_reset();
      // R3, R8: lead of 20, first outputs zero until the history covers the delay
      wr(20, "R2 readback lead 20");
      for (int i = 0; i < 30; i++) strobe("R3 R8 lead 20");
      // R5: out-of-window codes refused
      wr(600, "R5 reject 600");
      wr(400, "R5 reject 400");
      wr(511, "R5 reject 511");
      // R6: nonzero padding ignored
      wr(16'h0400 | 5, "R6 reject padded");
      wr(16'h8000, "R6 reject top bit");
      for (int i = 0; i < 4; i++) strobe("R5 R6 delay kept at 20");
      // R4, R9: lag of 7 from next strobe, using stored history
      wr(512 + 7, "R2 readback lag 7");
      for (int i = 0; i < 12; i++) strobe("R4 R9 lag 7");
      wr(0, "R2 readback zero");
      for (int i = 0; i < 3; i++) strobe("R7 R9 back to zero");
      // R3 boundary: maximum lead
      wr(383, "R2 readback 383");
      for (int i = 0; i < 400; i++) strobe("R3 lead 383");
      // R4 boundary: maximum lag, then one past it
      wr(575, "R2 readback 575");
      wr(576, "R5 reject 576");
      for (int i = 0; i < 70; i++) strobe("R4 lag 63");
      // R10: outputs hold between strobes while inputs move
      begin
         logic signed [SW-1:0] hc, hv;
         @(negedge clk);
         hc = cur_out; hv = volt_out;
         cur_in = 24'sd12345; volt_in = -24'sd4321;
         repeat (4) @(negedge clk);
         chk(cur_out == hc, "R10 hold current", cur_out, hc);
         chk(volt_out == hv, "R10 hold voltage", volt_out, hv);
      end
      // R8 on the voltage side after a fresh reset
      do_reset();
      wr(575, "R2 readback after reset");
      for (int i = 0; i < 70; i++) strobe("R8 R4 lag warm-up");
      repeat (3) @(negedge clk);
      chk(ec_q.size() == 0, "scoreboard drained", ec_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule